// File: doc/BRIEF.md
# Attribute Table Mailbox Responder

This block serves a fixed table of memory-attribute entries to a host through a pair of dword-wide mailboxes. The host writes a request object one dword at a time into the write mailbox and then raises a go strobe. The responder checks the request. If it is well formed, the responder assembles a response object in the read mailbox and raises a ready flag. The host then drains the response one dword per read strobe.

A response has three parts. First comes a three-dword header. It gives the vendor identifier, the object type and the total length, followed by the response code, the table selector and the handle of the entry that comes next. The contents of the requested entry follow the header. The reply length follows the byte size of the entry that was read, rounded up to whole dwords. After the last entry, the next-entry handle becomes all ones. A host can therefore walk the whole table by starting at handle 0 and following the returned handles until it sees that terminator.

The table is fixed when the block is built. It holds six entries in this order: one region-affinity entry, four latency/bandwidth entries (read latency, write latency, read bandwidth, write bandwidth) and one memory-type entry. All entries refer to region handle 0.

Top module: `tam_responder`

## Requirements
- R1: After reset, rsp_ready is 0, rd_len is 0 and rd_data is 0.
- R2: A request of fewer than 3 written dwords is discarded when req_go arrives. No response is built, so rsp_ready and rd_len stay 0.
- R3: A request whose handle (request dword 2, bits [31:16]) is 6 or more is discarded without a response.
- R4: Response dword 0 holds the vendor ID in [15:0], object type 8'h02 in [23:16] and zero in [31:24]. Response dword 1 holds the total response length in dwords, with all other bits zero.
- R5: The response length is 3 header dwords plus ceil(entry bytes / 4). The entry sizes are 24, 18, 18, 18, 18 and 20 bytes, which gives lengths 9, 8, 8, 8, 8 and 8.
- R6: Response dword 2 holds response code 8'h01 in [7:0], table selector 8'h00 in [15:8] and the next handle in [31:16]. The next handle is the request handle plus one, or 16'hFFFF for handle 5.
- R7: Entry contents start at response dword 3. The first entry dword is {byte size[31:16], 8'h00, kind[7:0]}, where the kind is 0 for affinity, 1 for latency/bandwidth and 2 for memory type. The second entry dword has the region handle 0 in [7:0]. Bytes past the entry size read as zero.
- R8: In latency/bandwidth entries, dword 4 holds flags 0 in [15:8] and the data type in [23:16]. The data types are 0 for read latency, 1 for write latency, 2 for read bandwidth and 3 for write bandwidth. Dwords 5 and 6 hold the 64-bit base unit: 10000 for latency and 1000 for bandwidth. Dword 7 holds the value in [15:0]: 15, 25, 16 and 16.
- R9: In the affinity entry, dword 4 has flags 8'h04 (non-volatile) in [15:8], the base in dwords 5 and 6 is 0, and the size in dwords 7 and 8 is MEM_BYTES. In the memory-type entry, dword 4 has attribute 8'h02 in [15:8], the offset in dword 5 is 0, and the size in dwords 6 and 7 is MEM_BYTES.
- R10: When a response is complete, rd_len grows by the response length. Each read strobe while the response is ready lowers rd_len by one.
- R11: rd_data shows the next unread dword, and each rd_strobe advances to the following one. rsp_ready falls once the last dword is consumed. A read strobe while rsp_ready is 0 has no effect.
- R12: A req_go that arrives while a response is still pending is discarded. The pending response, its position and rd_len are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write one request dword |
| req_data | input | 32 | Request dword |
| req_go | input | 1 | Request complete; check it and respond |
| rd_strobe | input | 1 | Consume the current read-mailbox dword |
| rd_data | output | 32 | Current read-mailbox dword |
| rd_len | output | 5 | Unread dwords in the read mailbox |
| rsp_ready | output | 1 | A response is waiting to be drained |

## Verification
The hardest case to reach from the ports is a new request that lands in the middle of draining a response. It needs a request that is valid on its own, arriving while the mailbox is partly consumed. The bench reaches it by reading two dwords of one entry's reply and then sending a complete request for a different handle. It then checks that the remaining dwords still belong to the first entry and that no second reply ever appears. The table walk itself follows the returned next handles, so an error in the terminator would stall or lengthen the walk.

// File: rtl/tam_pkg.sv
package tam_pkg;

    localparam int NUM_ENTRIES = 6;
    localparam int HDR_BYTES   = 12;
    localparam int HDR_DW      = (HDR_BYTES + 3) / 4;
    localparam int REQ_BYTES   = 12;
    localparam int REQ_DW      = (REQ_BYTES + 3) / 4;
    localparam int HANDLE_W    = 16;

    localparam logic [HANDLE_W-1:0] HANDLE_END = '1;
    localparam logic [7:0] OBJ_TYPE   = 8'h02;
    localparam logic [7:0] RSP_CODE   = 8'h01;
    localparam logic [7:0] TABLE_SEL  = 8'h00;
    localparam logic [7:0] REGION_ID  = 8'h00;
    localparam logic [7:0] FLAG_NVOL  = 8'h04;
    localparam logic [7:0] MEM_ATTR   = 8'h02;

    typedef enum logic [7:0] {
        KIND_AFFINITY = 8'h00,
        KIND_LATBW    = 8'h01,
        KIND_MEMTYPE  = 8'h02
    } entry_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BUILD,
        ST_READY
    } rsp_state_e;

    // Request dword 2 and response dword 2 share one layout
    typedef struct packed {
        logic [HANDLE_W-1:0] handle;
        logic [7:0]          table_sel;
        logic [7:0]          code;
    } sel_word_t;

    typedef struct packed {
        logic [7:0]  rsvd;
        logic [7:0]  obj_type;
        logic [15:0] vendor;
    } obj_hdr_t;

    function automatic entry_kind_e kind_of(input int idx);
        if (idx == 0)               return KIND_AFFINITY;
        if (idx == NUM_ENTRIES - 1) return KIND_MEMTYPE;
        return KIND_LATBW;
    endfunction

    function automatic int entry_bytes(input int idx);
        case (kind_of(idx))
            KIND_AFFINITY: return 24;
            KIND_MEMTYPE:  return 20;
            default:       return 18;
        endcase
    endfunction

    function automatic logic [31:0] entry_dword(input int idx, input int k,
                                                input logic [63:0] mem_bytes);
        entry_kind_e kind;
        int          sub;
        logic [31:0] unit;
        logic [15:0] val;
        kind = kind_of(idx);
        sub  = idx - 1;
        unit = (sub < 2) ? 32'd10000 : 32'd1000;
        val  = (sub == 0) ? 16'd15 : ((sub == 1) ? 16'd25 : 16'd16);
        if (idx < 0 || idx >= NUM_ENTRIES) return '0;
        if (k == 0) return {16'(entry_bytes(idx)), 8'h00, kind};
        case (kind)
            KIND_AFFINITY: begin
                case (k)
                    1:       return {16'h0000, FLAG_NVOL, REGION_ID};
                    4:       return mem_bytes[31:0];
                    5:       return mem_bytes[63:32];
                    default: return '0;
                endcase
            end
            KIND_LATBW: begin
                case (k)
                    1:       return {8'h00, 8'(sub), 8'h00, REGION_ID};
                    2:       return unit;
                    4:       return {16'h0000, val};
                    default: return '0;
                endcase
            end
            default: begin
                case (k)
                    1:       return {16'h0000, MEM_ATTR, REGION_ID};
                    3:       return mem_bytes[31:0];
                    4:       return mem_bytes[63:32];
                    default: return '0;
                endcase
            end
        endcase
    endfunction

endpackage

// File: rtl/tam_req_sink.sv
module tam_req_sink
    import tam_pkg::*;
#(
    parameter int CNT_W = $clog2(REQ_DW + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [31:0]         req_data,
    input  logic                req_go,
    output logic                len_ok,
    output logic [HANDLE_W-1:0] handle
);

    logic [CNT_W-1:0]    cnt_q;
    logic [HANDLE_W-1:0] handle_q;
    sel_word_t           word;
    logic                unused_fields;

    assign word          = sel_word_t'(req_data);
    assign unused_fields = ^{word.table_sel, word.code};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            handle_q <= '0;
        end else if (req_go) begin
            cnt_q <= '0;
        end else if (req_valid) begin
            if (cnt_q < CNT_W'(REQ_DW)) cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(REQ_DW - 1)) handle_q <= word.handle;
        end
    end

    assign len_ok = (cnt_q >= CNT_W'(REQ_DW));
    assign handle = handle_q;

endmodule

// File: rtl/tam_entry_rom.sv
module tam_entry_rom
    import tam_pkg::*;
#(
    parameter logic [63:0] MEM_BYTES = 64'h0000_0002_4000_0000,
    parameter int          IDX_W     = 4,
    parameter int          ENT_W     = $clog2(NUM_ENTRIES)
) (
    input  logic [ENT_W-1:0] entry_idx,
    input  logic [IDX_W-1:0] dw_idx,
    output logic [31:0]      dword,
    output logic [IDX_W:0]   len_dw
);

    localparam int SLOTS = 1 << ENT_W;

    logic [IDX_W:0] len_tbl [SLOTS];

    for (genvar e = 0; e < SLOTS; e++) begin : g_len
        if (e < NUM_ENTRIES) begin : g_live
            assign len_tbl[e] = (IDX_W+1)'(HDR_DW + (entry_bytes(e) + 3) / 4);
        end else begin : g_pad
            assign len_tbl[e] = '0;
        end
    end

    assign len_dw = len_tbl[entry_idx];
    assign dword  = entry_dword(int'(entry_idx), int'(dw_idx), MEM_BYTES);

endmodule

// File: rtl/tam_rsp_builder.sv
module tam_rsp_builder
    import tam_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID = 16'h1E98,
    parameter logic [63:0] MEM_BYTES = 64'h0000_0002_4000_0000,
    parameter int          RD_DEPTH  = 16,
    parameter int          IDX_W     = $clog2(RD_DEPTH),
    parameter int          LEN_W     = $clog2(RD_DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                go,
    input  logic                len_ok,
    input  logic [HANDLE_W-1:0] handle_in,
    input  logic                rd_strobe,
    output logic [31:0]         rd_data,
    output logic [LEN_W-1:0]    rd_len,
    output logic                rsp_ready
);

    localparam int ENT_W = $clog2(NUM_ENTRIES);

    rsp_state_e          state_q;
    logic [IDX_W-1:0]    wr_idx_q;
    logic [IDX_W-1:0]    rd_ptr_q;
    logic [LEN_W-1:0]    rd_len_q;
    logic [HANDLE_W-1:0] cur_q;
    logic [31:0]         mbox_q [RD_DEPTH];

    logic                accept;
    logic [IDX_W-1:0]    ent_dw;
    logic [31:0]         rom_dword;
    logic [IDX_W:0]      rsp_len;
    logic [HANDLE_W-1:0] next_handle;
    logic [31:0]         word;
    obj_hdr_t            hdr;
    sel_word_t           sel;

    assign accept = go && len_ok && (handle_in < HANDLE_W'(NUM_ENTRIES))
                    && (state_q == ST_IDLE);

    assign ent_dw = wr_idx_q - IDX_W'(HDR_DW);

    tam_entry_rom #(
        .MEM_BYTES (MEM_BYTES),
        .IDX_W     (IDX_W),
        .ENT_W     (ENT_W)
    ) rom_i (
        .entry_idx (cur_q[ENT_W-1:0]),
        .dw_idx    (ent_dw),
        .dword     (rom_dword),
        .len_dw    (rsp_len)
    );

    assign next_handle = (cur_q == HANDLE_W'(NUM_ENTRIES - 1)) ? HANDLE_END
                                                                : cur_q + 1'b1;

    always_comb begin
        hdr.rsvd      = 8'h00;
        hdr.obj_type  = OBJ_TYPE;
        hdr.vendor    = VENDOR_ID;
        sel.handle    = next_handle;
        sel.table_sel = TABLE_SEL;
        sel.code      = RSP_CODE;
        case (wr_idx_q)
            IDX_W'(0): word = hdr;
            IDX_W'(1): word = 32'(rsp_len);
            IDX_W'(2): word = sel;
            default:   word = rom_dword;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            wr_idx_q <= '0;
            rd_ptr_q <= '0;
            rd_len_q <= '0;
            cur_q    <= '0;
            for (int i = 0; i < RD_DEPTH; i++) mbox_q[i] <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        cur_q    <= handle_in;
                        wr_idx_q <= '0;
                        state_q  <= ST_BUILD;
                    end
                end
                ST_BUILD: begin
                    mbox_q[wr_idx_q] <= word;
                    wr_idx_q         <= wr_idx_q + 1'b1;
                    if ({1'b0, wr_idx_q} == rsp_len - 1'b1) begin
                        rd_len_q <= rd_len_q + LEN_W'(rsp_len);
                        rd_ptr_q <= '0;
                        state_q  <= ST_READY;
                    end
                end
                default: begin
                    if (rd_strobe) begin
                        rd_ptr_q <= rd_ptr_q + 1'b1;
                        rd_len_q <= rd_len_q - 1'b1;
                        if (rd_len_q == LEN_W'(1)) state_q <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    assign rsp_ready = (state_q == ST_READY);
    assign rd_data   = rsp_ready ? mbox_q[rd_ptr_q] : '0;
    assign rd_len    = rd_len_q;

endmodule

// File: rtl/tam_responder.sv
module tam_responder
    import tam_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID = 16'h1E98,
    parameter logic [63:0] MEM_BYTES = 64'h0000_0002_4000_0000,
    parameter int          RD_DEPTH  = 16,
    parameter int          LEN_W     = $clog2(RD_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [31:0]      req_data,
    input  logic             req_go,
    input  logic             rd_strobe,
    output logic [31:0]      rd_data,
    output logic [LEN_W-1:0] rd_len,
    output logic             rsp_ready
);

    logic                len_ok;
    logic [HANDLE_W-1:0] req_handle;

    tam_req_sink sink_i (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_data  (req_data),
        .req_go    (req_go),
        .len_ok    (len_ok),
        .handle    (req_handle)
    );

    tam_rsp_builder #(
        .VENDOR_ID (VENDOR_ID),
        .MEM_BYTES (MEM_BYTES),
        .RD_DEPTH  (RD_DEPTH),
        .LEN_W     (LEN_W)
    ) build_i (
        .clk       (clk),
        .rst       (rst),
        .go        (req_go),
        .len_ok    (len_ok),
        .handle_in (req_handle),
        .rd_strobe (rd_strobe),
        .rd_data   (rd_data),
        .rd_len    (rd_len),
        .rsp_ready (rsp_ready)
    );

endmodule

// File: rtl/tam_responder_chk.sv
module tam_responder_chk
    import tam_pkg::*;
#(
    parameter int LEN_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             rd_strobe,
    input logic [31:0]      rd_data,
    input logic [LEN_W-1:0] rd_len,
    input logic             rsp_ready
);

    // R10: nothing is counted in the mailbox unless a response is pending
    a_r10_empty_when_idle: assert property (@(posedge clk) disable iff (rst)
        !rsp_ready |-> rd_len == '0);

    // R10: each consumed dword lowers the count by one
    a_r10_drain_count: assert property (@(posedge clk) disable iff (rst)
        (rsp_ready && rd_strobe) |=> rd_len == $past(rd_len) - 1'b1);

    // R11: consuming the final dword drops the ready flag
    a_r11_last_clears: assert property (@(posedge clk) disable iff (rst)
        (rsp_ready && rd_strobe && rd_len == LEN_W'(1)) |=> !rsp_ready);

    // R11, R12: without a strobe a pending response holds still
    a_r12_pending_hold: assert property (@(posedge clk) disable iff (rst)
        (rsp_ready && !rd_strobe) |=> (rsp_ready && $stable(rd_data) && $stable(rd_len)));

    // R4: the first dword shown is the object header
    a_r4_header_first: assert property (@(posedge clk) disable iff (rst)
        $rose(rsp_ready) |-> (rd_data[31:24] == 8'h00 && rd_data[23:16] == OBJ_TYPE));

    // R5: a fresh response is 8 or 9 dwords long
    a_r5_len_range: assert property (@(posedge clk) disable iff (rst)
        $rose(rsp_ready) |-> (rd_len == LEN_W'(8) || rd_len == LEN_W'(9)));

endmodule

bind tam_responder tam_responder_chk #(.LEN_W(LEN_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .rd_strobe (rd_strobe),
    .rd_data   (rd_data),
    .rd_len    (rd_len),
    .rsp_ready (rsp_ready)
);

// File: tb/tam_responder_tb_top.sv
module tam_responder_tb_top;

    localparam logic [15:0] VID = 16'h1E98;
    localparam logic [63:0] MEM = 64'h0000_0002_4000_0000;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [31:0] req_data;
    logic        req_go;
    logic        rd_strobe;
    logic [31:0] rd_data;
    logic [4:0]  rd_len;
    logic        rsp_ready;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    tam_responder dut_i (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_data  (req_data),
        .req_go    (req_go),
        .rd_strobe (rd_strobe),
        .rd_data   (rd_data),
        .rd_len    (rd_len),
        .rsp_ready (rsp_ready)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int exp_len(input int h);
        return (h == 0) ? 9 : 8;
    endfunction

    function automatic logic [31:0] exp_dw(input int h, input int k);
        int j = k - 3;
        int t = h - 1;
        if (k == 0) return {8'h00, 8'h02, VID};
        if (k == 1) return 32'(exp_len(h));
        if (k == 2) return {((h == 5) ? 16'hFFFF : 16'(h + 1)), 8'h00, 8'h01};
        if (h == 0) begin
            case (j)
                0: return {16'd24, 8'h00, 8'h00};
                1: return {16'h0000, 8'h04, 8'h00};
                4: return MEM[31:0];
                5: return MEM[63:32];
                default: return 32'h0;
            endcase
        end else if (h == 5) begin
            case (j)
                0: return {16'd20, 8'h00, 8'h02};
                1: return {16'h0000, 8'h02, 8'h00};
                3: return MEM[31:0];
                4: return MEM[63:32];
                default: return 32'h0;
            endcase
        end
        case (j)
            0: return {16'd18, 8'h00, 8'h01};
            1: return {8'h00, 8'(t), 16'h0000};
            2: return (t < 2) ? 32'd10000 : 32'd1000;
            4: return (t == 0) ? 32'd15 : ((t == 1) ? 32'd25 : 32'd16);
            default: return 32'h0;
        endcase
    endfunction

    function automatic string req_of(input int h, input int k);
        if (k < 2) return "R4";
        if (k == 2) return "R6";
        if (k < 5) return "R7";
        if (h == 0 || h == 5) return "R9";
        return "R8";
    endfunction

    task automatic send_req(input int ndw, input logic [15:0] handle);
        for (int i = 0; i < ndw; i++) begin
            req_valid = 1'b1;
            case (i)
                0: req_data = {8'h00, 8'h02, VID};
                1: req_data = 32'(ndw);
                default: req_data = {handle, 8'h00, 8'h00};
            endcase
            @(negedge clk);
        end
        req_valid = 1'b0;
        req_go    = 1'b1;
        @(negedge clk);
        req_go    = 1'b0;
    endtask

    task automatic wait_ready(output bit got);
        got = 0;
        for (int i = 0; i < 40; i++) begin
            if (rsp_ready) begin
                got = 1;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic strobe();
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    // Read a full reply for handle h, starting at dword 'from'; returns next handle
    task automatic drain(input int h, input int from, output logic [15:0] nxt);
        int len = exp_len(h);
        nxt = 16'hxxxx;
        for (int k = from; k < len; k++) begin
            check(rd_len == 5'(len - k), "R10", 32'(rd_len), 32'(len - k));
            check(rd_data == exp_dw(h, k), req_of(h, k), rd_data, exp_dw(h, k));
            if (k == 2) nxt = rd_data[31:16];
            strobe();
        end
        check(rsp_ready == 1'b0, "R11", 32'(rsp_ready), 32'd0);
        check(rd_len == 5'd0, "R10", 32'(rd_len), 32'd0);
    endtask

    task automatic test_reset();
        check(rsp_ready == 1'b0, "R1", 32'(rsp_ready), 32'd0);
        check(rd_len == 5'd0, "R1", 32'(rd_len), 32'd0);
        check(rd_data == 32'd0, "R1", rd_data, 32'd0);
    endtask

    task automatic test_walk();
        logic [15:0] h = 16'd0;
        logic [15:0] nxt;
        bit got;
        for (int n = 0; n < 6; n++) begin
            send_req(3, h);
            wait_ready(got);
            check(got, "R5", 32'(got), 32'd1);
            if (!got) return;
            check(rd_len == 5'(exp_len(int'(h))), "R5", 32'(rd_len), 32'(exp_len(int'(h))));
            drain(int'(h), 0, nxt);
            h = nxt;
        end
        check(h == 16'hFFFF, "R6", 32'(h), 32'hFFFF);
    endtask

    task automatic test_no_reply(input int ndw, input logic [15:0] handle, input string req);
        send_req(ndw, handle);
        repeat (20) @(negedge clk);
        check(rsp_ready == 1'b0, req, 32'(rsp_ready), 32'd0);
        check(rd_len == 5'd0, req, 32'(rd_len), 32'd0);
    endtask

    task automatic test_longer_req();
        logic [15:0] nxt;
        bit got;
        send_req(5, 16'd3);
        wait_ready(got);
        check(got, "R2", 32'(got), 32'd1);
        if (got) drain(3, 0, nxt);
    endtask

    task automatic test_idle_strobe();
        logic [15:0] nxt;
        bit got;
        strobe();
        strobe();
        check(rd_len == 5'd0, "R11", 32'(rd_len), 32'd0);
        send_req(3, 16'd5);
        wait_ready(got);
        check(got, "R11", 32'(got), 32'd1);
        if (got) drain(5, 0, nxt);
    endtask

    task automatic test_pending();
        logic [15:0] nxt;
        bit got;
        send_req(3, 16'd1);
        wait_ready(got);
        check(got, "R12", 32'(got), 32'd1);
        if (!got) return;
        strobe();
        strobe();
        send_req(3, 16'd0);
        repeat (12) @(negedge clk);
        check(rd_len == 5'd6, "R12", 32'(rd_len), 32'd6);
        check(rd_data == exp_dw(1, 2), "R12", rd_data, exp_dw(1, 2));
        drain(1, 2, nxt);
        repeat (20) @(negedge clk);
        check(rsp_ready == 1'b0, "R12", 32'(rsp_ready), 32'd0);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst       = 1'b1;
        req_valid = 1'b0;
        req_data  = '0;
        req_go    = 1'b0;
        rd_strobe = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_walk();
        test_no_reply(2, 16'd0, "R2");
        test_no_reply(3, 16'd6, "R3");
        test_no_reply(3, 16'hFFFF, "R3");
        test_longer_req();
        test_idle_strobe();
        test_pending();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule